// File: doc/BRIEF.md
# Perfect Destination Address Filter

This block decides whether a received Ethernet frame is kept, based on the frame's 48-bit destination address. It keeps a table of 16 exact-match addresses. A neighbouring receive path presents each destination address on a lookup strobe. One cycle later the block returns an accept decision and two status flags. The first flag says the frame was kept only because of an accept-everything mode (filtering fail). The second says it was kept only because multicast pass-through is on.

The table is written by streaming a setup frame into the block, one byte per cycle, with a last-byte marker. The setup frame is 192 bytes long. Each table entry uses a 12-byte slot, and only six bytes of each slot carry address data. The new table takes effect only if the frame length is exactly 192 bytes. While a setup frame is streaming, the block raises a busy signal and ignores lookups. Four mode inputs change the decision, and a fixed priority decides between them.

Top module: `dest_addr_filter`

## Requirements
- R1: The table holds 16 entries of 48 bits. Reset clears every entry to zero, so after reset the address 00:00:00:00:00:00 matches the table and any other unicast address does not (modes clear).
- R2: A setup frame is the run of `cfg_valid` bytes that ends with the byte carrying `cfg_last`. The table is replaced at the clock edge of that last byte, and only when the frame has exactly 192 bytes. A shorter or longer frame leaves all 16 entries unchanged.
- R3: Entry n is taken from the setup-frame bytes at offsets 12n+0, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9. These become address bytes 0 to 5 in that order. All other setup bytes are ignored.
- R4: The address is given with byte 0 (the first byte on the wire) in `lk_addr[47:40]`. The all-ones address is accepted in every mode, with both flags clear.
- R5: For a non-broadcast address with `md_promisc` or `md_rx_all` set, the frame is accepted with the filtering-fail flag set and the multicast flag clear, whether or not it matches.
- R6: For a non-broadcast address with neither of those modes set, `md_mcast_all` set and `lk_addr[40]` = 1 (the group bit of byte 0), the frame is accepted with the multicast flag set and the filtering-fail flag clear.
- R7: In every other case, accept is "matches one of the 16 entries", inverted when `md_inverse` is set, with both flags clear.
- R8: A lookup is taken when `lk_valid` is high and `cfg_busy` is low. Its result appears on the outputs one clock after, qualified by a single-cycle `res_valid` pulse. All 16 entries are compared in parallel.
- R9: `cfg_busy` rises the clock after the first byte of a setup frame and falls the clock after its last byte. A lookup presented while `cfg_busy` is high produces no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Setup-frame byte present |
| cfg_byte | input | 8 | Setup-frame byte |
| cfg_last | input | 1 | Marks the final byte of the setup frame |
| cfg_busy | output | 1 | Setup load in progress; lookups are dropped |
| lk_valid | input | 1 | Destination address presented |
| lk_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| md_promisc | input | 1 | Promiscuous mode |
| md_rx_all | input | 1 | Receive-all mode |
| md_mcast_all | input | 1 | Pass all multicast frames |
| md_inverse | input | 1 | Invert the perfect-match result |
| res_valid | output | 1 | Decision present (one cycle) |
| res_accept | output | 1 | Frame accepted |
| res_ff | output | 1 | Accepted only by promiscuous or receive-all mode |
| res_mf | output | 1 | Accepted only by multicast pass-through |

## Verification
The table is loaded with entries whose bytes all differ from the filler bytes and from each other. This shows whether the strided offsets were picked correctly, and a lookup of the first and last entries shows both ends of the table. The same group of addresses (member, non-member, multicast, broadcast) is looked up under each mode combination, including combinations where several rules apply at once, so an error in the priority order changes a result. Setup frames of 180 and 193 bytes are then streamed, and the bench checks that the old table still answers. Reset lookups of the zero address and of a table member show the cleared state, and a lookup placed in the middle of a setup stream shows that busy drops lookups.

// File: rtl/amf_pkg.sv
// Package for the destination address filter.
// Holds the layout constants of the setup frame and the packed mode word.
// Assumes 8-bit setup bytes and 6-byte addresses.
package amf_pkg;

    localparam int SLOT_BYTES = 12;   // setup-frame bytes per table entry
    localparam int ADDR_BYTES = 6;    // address bytes per entry

    typedef struct packed {
        logic promisc;
        logic rx_all;
        logic mcast_all;
        logic inverse;
    } amf_mode_t;

endpackage

// File: rtl/amf_setup_loader.sv
// Setup-frame loader.
// Counts setup bytes and puts address bytes from the strided slot layout
// into a staging copy of the table. At the last byte it raises commit, but
// only if the frame is exactly ENTRIES*12 bytes long.
// Assumes one byte per cycle while cfg_valid is high.
module amf_setup_loader
    import amf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_valid,
    input  logic [7:0]            cfg_byte,
    input  logic                  cfg_last,
    output logic                  busy,
    output logic                  commit,
    output logic [ENTRIES*AW-1:0] stage_flat
);
    localparam int SETUP_LEN = ENTRIES * SLOT_BYTES;
    localparam int LW        = $clog2(SETUP_LEN + 2);
    localparam int EW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [LW-1:0] LEN_SAT  = LW'(SETUP_LEN + 1);
    localparam logic [LW-1:0] LEN_LAST = LW'(SETUP_LEN - 1);
    localparam logic [LW-1:0] LEN_FULL = LW'(SETUP_LEN);

    logic [LW-1:0] len_cnt;
    logic [EW-1:0] ent_cnt;
    logic [3:0]    rel_cnt;
    logic [AW-1:0] stage [ENTRIES];
    logic [2:0]    byte_idx;
    logic          keep_byte;

    // Position of an address byte inside the slot: relative offsets 0,1,4,5,8,9 give bytes 0..5
    assign byte_idx  = {rel_cnt[3:2], rel_cnt[0]};
    assign keep_byte = cfg_valid && (len_cnt < LEN_FULL) && !rel_cnt[1];

    // Byte, slot and entry counters for the setup frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_cnt <= '0;
            ent_cnt <= '0;
            rel_cnt <= '0;
        end else if (cfg_valid) begin
            if (cfg_last) begin
                len_cnt <= '0;
                ent_cnt <= '0;
                rel_cnt <= '0;
            end else begin
                if (len_cnt != LEN_SAT)
                    len_cnt <= len_cnt + 1'b1;
                if (rel_cnt == 4'(SLOT_BYTES - 1)) begin
                    rel_cnt <= '0;
                    ent_cnt <= ent_cnt + 1'b1;
                end else begin
                    rel_cnt <= rel_cnt + 1'b1;
                end
            end
        end
    end

    // Staging copy of the table, written byte by byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                stage[i] <= '0;
        end else if (keep_byte) begin
            stage[ent_cnt][AW-1-8*int'(byte_idx) -: 8] <= cfg_byte;
        end
    end

    // Busy flag from the first byte through the last byte of a frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (cfg_valid)
            busy <= !cfg_last;
    end

    // Commit only at the last byte of a frame of exactly the right length
    assign commit = cfg_valid && cfg_last && (len_cnt == LEN_LAST);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign stage_flat[g*AW +: AW] = stage[g];
    end

    // R9: any non-final setup byte leaves busy high in the next cycle
    p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_last |=> busy);

    // R9: the final byte clears busy in the next cycle
    p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_last |=> !busy);

endmodule

// File: rtl/amf_cam_table.sv
// Perfect-match address table.
// Holds ENTRIES addresses, loads all of them from the staging copy on
// commit, and compares the lookup key with every entry in parallel.
// Assumes commit is a single-cycle pulse from the loader.
module amf_cam_table #(
    parameter int ENTRIES = 16,
    parameter int AW      = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [ENTRIES*AW-1:0] stage_flat,
    input  logic [AW-1:0]         key,
    output logic [ENTRIES-1:0]    hit
);
    logic [ENTRIES*AW-1:0] table_q;

    // Table register: cleared by reset, replaced as a whole on commit
    always_ff @(posedge clk) begin
        if (!rst_n)
            table_q <= '0;
        else if (commit)
            table_q <= stage_flat;
    end

    // One comparator per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit[g] = (table_q[g*AW +: AW] == key);
    end

    // R2: without a commit the table does not change
    p_table_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(table_q));

endmodule

// File: rtl/amf_decide.sv
// Decision stage.
// Applies the rules in priority order (broadcast, promiscuous or receive-all,
// multicast pass, then perfect match or inverse) and registers the result
// one cycle after an accepted lookup.
// Assumes hit[] belongs to the same key presented on this cycle.
module amf_decide
    import amf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [AW-1:0]      key,
    input  logic [ENTRIES-1:0] hit,
    input  amf_mode_t          mode,
    output logic               res_valid,
    output logic               res_accept,
    output logic               res_ff,
    output logic               res_mf
);
    logic is_bcast;
    logic is_group;
    logic any_hit;
    logic d_accept;
    logic d_ff;
    logic d_mf;

    assign is_bcast = &key;
    assign is_group = key[AW-8];
    assign any_hit  = |hit;

    // Priority chain of the filtering rules
    always_comb begin
        d_accept = 1'b0;
        d_ff     = 1'b0;
        d_mf     = 1'b0;
        if (is_bcast) begin
            d_accept = 1'b1;
        end else if (mode.promisc || mode.rx_all) begin
            d_accept = 1'b1;
            d_ff     = 1'b1;
        end else if (mode.mcast_all && is_group) begin
            d_accept = 1'b1;
            d_mf     = 1'b1;
        end else begin
            d_accept = any_hit ^ mode.inverse;
        end
    end

    // Result register, loaded on each accepted lookup
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_ff     <= 1'b0;
            res_mf     <= 1'b0;
        end else begin
            res_valid <= go;
            if (go) begin
                res_accept <= d_accept;
                res_ff     <= d_ff;
                res_mf     <= d_mf;
            end
        end
    end

    // R4: broadcast is accepted with clean flags
    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go && is_bcast |=> res_accept && !res_ff && !res_mf);

    // R5: accept-everything modes set the filtering-fail flag
    p_promisc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go && !is_bcast && (mode.promisc || mode.rx_all) |=> res_accept && res_ff && !res_mf);

    // R6: multicast pass sets the multicast flag
    p_mcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go && !is_bcast && !mode.promisc && !mode.rx_all && mode.mcast_all && is_group
        |=> res_accept && res_mf && !res_ff);

    // R7: otherwise the table result, inverted under inverse mode
    p_perfect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go && !is_bcast && !mode.promisc && !mode.rx_all && !(mode.mcast_all && is_group)
        |=> (res_accept == ($past(any_hit) ^ $past(mode.inverse))) && !res_ff && !res_mf);

    // R8: exactly one result per accepted lookup, one cycle later
    p_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> res_valid);
    p_no_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !res_valid);

endmodule

// File: rtl/dest_addr_filter.sv
// Perfect destination address filter, top level.
// Connects the setup loader, the 16-entry match table and the decision stage.
// A lookup is taken only while no setup frame is streaming.
// Assumes lk_addr carries byte 0 of the address in bits 47:40.
module dest_addr_filter
    import amf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int AW      = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic [7:0]    cfg_byte,
    input  logic          cfg_last,
    output logic          cfg_busy,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic          md_promisc,
    input  logic          md_rx_all,
    input  logic          md_mcast_all,
    input  logic          md_inverse,
    output logic          res_valid,
    output logic          res_accept,
    output logic          res_ff,
    output logic          res_mf
);
    logic                  commit;
    logic [ENTRIES*AW-1:0] stage_flat;
    logic [ENTRIES-1:0]    hit;
    logic                  go;
    amf_mode_t             mode;

    assign go   = lk_valid && !cfg_busy;
    assign mode = '{promisc: md_promisc, rx_all: md_rx_all,
                    mcast_all: md_mcast_all, inverse: md_inverse};

    amf_setup_loader #(.ENTRIES(ENTRIES), .AW(AW)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_byte   (cfg_byte),
        .cfg_last   (cfg_last),
        .busy       (cfg_busy),
        .commit     (commit),
        .stage_flat (stage_flat)
    );

    amf_cam_table #(.ENTRIES(ENTRIES), .AW(AW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .stage_flat (stage_flat),
        .key        (lk_addr),
        .hit        (hit)
    );

    amf_decide #(.ENTRIES(ENTRIES), .AW(AW)) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .key        (lk_addr),
        .hit        (hit),
        .mode       (mode),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_ff     (res_ff),
        .res_mf     (res_mf)
    );

    // R9: a lookup presented while busy yields no result
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && cfg_busy |=> !res_valid);

    // R5/R6: the two status flags never appear together
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_ff && res_mf));

endmodule

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        cfg_last = 1'b0;
    logic        cfg_busy;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        md_promisc = 1'b0;
    logic        md_rx_all = 1'b0;
    logic        md_mcast_all = 1'b0;
    logic        md_inverse = 1'b0;
    logic        res_valid;
    logic        res_accept;
    logic        res_ff;
    logic        res_mf;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    dest_addr_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_byte(cfg_byte), .cfg_last(cfg_last), .cfg_busy(cfg_busy),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .md_promisc(md_promisc), .md_rx_all(md_rx_all),
        .md_mcast_all(md_mcast_all), .md_inverse(md_inverse),
        .res_valid(res_valid), .res_accept(res_accept), .res_ff(res_ff), .res_mf(res_mf)
    );

    // Vector: {promisc, rx_all, mcast_all, inverse, address, accept, ff, mf}
    localparam int NV = 16;
    localparam logic [54:0] VEC [NV] = '{
        {4'b0000, 48'h0211_0033_4455, 3'b100},  // R3 first entry
        {4'b0000, 48'h0211_0F33_4464, 3'b100},  // R3 last entry
        {4'b0000, 48'h0211_2033_4455, 3'b000},  // R7 non-member
        {4'b0000, 48'hFFFF_FFFF_FFFF, 3'b100},  // R4
        {4'b0001, 48'h0211_0333_4458, 3'b000},  // R7 inverse member
        {4'b0001, 48'h0211_2033_4455, 3'b100},  // R7 inverse non-member
        {4'b1000, 48'h0211_2033_4455, 3'b110},  // R5 promisc
        {4'b0100, 48'h0211_2033_4455, 3'b110},  // R5 rx_all
        {4'b1000, 48'h0211_0233_4457, 3'b110},  // R5 over a match
        {4'b0010, 48'h0100_5E00_0001, 3'b101},  // R6
        {4'b0000, 48'h0100_5E00_0001, 3'b000},  // R7 multicast without pass
        {4'b1010, 48'h0100_5E00_0001, 3'b110},  // R5 before R6
        {4'b0011, 48'h0211_0433_4459, 3'b000},  // R6 needs group bit, R7 inverse
        {4'b1111, 48'hFFFF_FFFF_FFFF, 3'b100},  // R4 before all
        {4'b0011, 48'h0100_5E00_0001, 3'b101},  // R6 before inverse
        {4'b0001, 48'hFFFF_FFFF_FFFF, 3'b100}   // R4 under inverse
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {valid,accept,ff,mf} actual %b expected %b", tag, act, exp);
        end
    endtask

    // One lookup; result sampled at the falling edge after the taking edge
    task automatic lookup(input logic [3:0] md, input logic [47:0] a, output logic [3:0] r);
        @(negedge clk);
        {md_promisc, md_rx_all, md_mcast_all, md_inverse} = md;
        lk_addr  = a;
        lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
        r = {res_valid, res_accept, res_ff, res_mf};
    endtask

    // Setup byte generator: kind 0 gives entry n = 02 11 nn 33 44 55+n, filler EE
    function automatic logic [7:0] setup_byte(input int i, input int kind);
        int n = i / 12;
        int rel = i % 12;
        if (kind != 0) return 8'h77;
        case (rel)
            0: return 8'h02;
            1: return 8'h11;
            4: return 8'(n);
            5: return 8'h33;
            8: return 8'h44;
            9: return 8'(8'h55 + n);
            default: return 8'hEE;
        endcase
    endfunction

    // Streams a setup frame; probes busy and a dropped lookup on the way
    task automatic send_setup(input int len, input int kind);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 1) chk("R9 busy during load", {3'b000, cfg_busy}, 4'b0001);
            if (i == 11) chk("R9 lookup dropped while busy", {res_valid, 3'b000}, 4'b0000);
            lk_valid  = (i == 10);
            lk_addr   = 48'h0000_0000_0000;
            cfg_valid = 1'b1;
            cfg_byte  = setup_byte(i, kind);
            cfg_last  = (i == len - 1);
        end
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_last  = 1'b0;
        lk_valid  = 1'b0;
        chk("R9 busy clear after last byte", {3'b000, cfg_busy}, 4'b0000);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] r;
        repeat (3) @(negedge clk);
        chk("R8 reset state", {res_valid, res_accept, res_ff, res_mf}, 4'b0000);
        chk("R9 reset busy", {3'b000, cfg_busy}, 4'b0000);
        rst_n = 1'b1;

        // R1: cleared table matches the zero address only
        lookup(4'b0000, 48'h0, r);
        chk("R1 zero address after reset", r, 4'b1100);
        lookup(4'b0000, 48'h0211_0033_4455, r);
        chk("R1 unicast after reset", r, 4'b1000);
        @(negedge clk);
        chk("R8 single-cycle valid", {res_valid, 3'b000}, 4'b0000);

        // R2/R3: load a full table
        send_setup(192, 0);
        chk("R2 no result from dropped lookup", {res_valid, 3'b000}, 4'b0000);

        // Main vector walk (R3..R7)
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][54:51], VEC[v][50:3], r);
            chk($sformatf("R4-R7 vector %0d", v), r, {1'b1, VEC[v][2:0]});
        end

        // R2: a short frame leaves the table as it was
        send_setup(180, 1);
        lookup(4'b0000, 48'h0211_0033_4455, r);
        chk("R2 short frame keeps old entry", r, 4'b1100);
        lookup(4'b0000, 48'h7777_7777_7777, r);
        chk("R2 short frame not loaded", r, 4'b1000);

        // R2: a long frame leaves the table as it was
        send_setup(193, 1);
        lookup(4'b0000, 48'h0211_0F33_4464, r);
        chk("R2 long frame keeps old entry", r, 4'b1100);
        lookup(4'b0000, 48'h7777_7777_7777, r);
        chk("R2 long frame not loaded", r, 4'b1000);

        // R2: an exact frame of new content does replace it
        send_setup(192, 1);
        lookup(4'b0000, 48'h7777_7777_7777, r);
        chk("R2 exact frame loaded", r, 4'b1100);
        lookup(4'b0000, 48'h0211_0033_4455, r);
        chk("R2 old entry gone", r, 4'b1000);

        summary();
        $finish;
    end

endmodule